// File: doc/BRIEF.md
# Programmable Almost-Empty / Almost-Full Flag Unit

This block produces the two early-warning status flags of a dual-clock FIFO. It takes the binary write pointer (write-clock domain) and the binary read pointer (read-clock domain), each one bit wider than the address so that a full buffer can be told apart from an empty one. It compares the fill level against two programmable thresholds: an empty-side offset for the almost-empty flag and a full-side offset for the almost-full flag.

Both thresholds start from one of eight preset values, chosen by a 3-bit select that is captured while master reset is held. The load method and the flag timing are captured at the same time. The load method is either a parallel word bus or a one-bit serial stream, both clocked by the write clock. The flag timing is either asynchronous, where both flags follow the two raw pointers directly, or synchronous. In synchronous timing the almost-empty flag is registered on the read clock and the almost-full flag on the write clock, and each uses a gray-coded copy of the opposite pointer passed through a two-stage synchronizer. Partial reset keeps the programmed thresholds and restarts the load sequence. Master reset brings back the preset defaults.

Top module: `pf_flag_unit`

## Requirements
- R1: When master reset is released, both offsets equal PRESETS[dflt_sel]. The defaults for select codes 0..7 are 7, 15, 31, 63, 127, 255, 511 and 1023. With equal pointers, ae_flag is 1 and af_flag is 0.
- R2: ae_flag is 1 exactly when the fill level, (wr_ptr - rd_ptr) modulo 2^(ADDR_W+1), is less than or equal to the empty offset. This includes the case where the pointers have wrapped.
- R3: af_flag is 1 exactly when the free space, 2^ADDR_W minus the fill level, is less than or equal to the full offset.
- R4: In parallel mode, each write-clock cycle with ld_en high stores ld_data into one offset. Stores alternate, starting with the empty offset and then the full offset.
- R5: Holding prst_n low leaves both offsets unchanged and returns the parallel load target to the empty offset.
- R6: In serial mode, each write-clock cycle with ser_en high shifts in ser_bit. The first ADDR_W bits fill the empty offset, LSB first. The next ADDR_W bits fill the full offset, LSB first. Further bits are ignored until a partial or master reset.
- R7: ld_en has no effect in serial mode, and ser_en has no effect in parallel mode.
- R8: A master reset after programming restores the preset selected by dflt_sel, replacing any loaded offsets.
- R9: In asynchronous timing (sync_sel = 0 at master reset), both flags follow a pointer change without waiting for any clock edge.
- R10: In synchronous timing (sync_sel = 1 at master reset), a pointer change does not reach the flags combinationally. It appears after the synchronizer and flag register delay, which is no more than six edges of the slower clock.
- R11: dflt_sel, ser_load_sel and sync_sel are used only while mrst_n is low. Changing them afterwards has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock; clocks offset loading and the almost-full register |
| rd_clk | input | 1 | Read-side clock; clocks the almost-empty register |
| mrst_n | input | 1 | Master reset, active low, synchronous, held for several cycles of both clocks |
| prst_n | input | 1 | Partial reset, active low; keeps offsets |
| dflt_sel | input | 3 | Preset offset select, captured during master reset |
| ser_load_sel | input | 1 | 1 = serial offset loading, 0 = parallel; captured during master reset |
| sync_sel | input | 1 | 1 = synchronous flag timing, 0 = asynchronous; captured during master reset |
| wr_ptr | input | ADDR_W+1 | Binary write pointer, write-clock domain |
| rd_ptr | input | ADDR_W+1 | Binary read pointer, read-clock domain |
| ld_en | input | 1 | Parallel offset write strobe |
| ld_data | input | ADDR_W | Parallel offset value |
| ser_en | input | 1 | Serial shift enable |
| ser_bit | input | 1 | Serial offset data bit |
| ae_flag | output | 1 | Almost-empty flag |
| af_flag | output | 1 | Almost-full flag |

## Verification
The hardest condition to reach from the ports is the boundary of a serially loaded offset. The bench has to know which of the twenty shifted bits ended up where, and that bits past the twentieth were dropped. It sends a full stream with distinct empty and full values, followed by extra ones, and then probes each threshold from both sides with exact fill levels. The synchronous path is the other hard case. There the bench changes a pointer and samples at once, expecting no change, and samples again only after the synchronizer has settled.

// File: rtl/pflag_pkg.sv
package pflag_pkg;
    typedef enum logic { LD_PARALLEL = 1'b0, LD_SERIAL = 1'b1 } load_e;
    typedef enum logic { TM_ASYNC = 1'b0, TM_SYNC = 1'b1 } timing_e;

    typedef struct packed {
        load_e   load;
        timing_e timing;
    } cfg_t;
endpackage

// File: rtl/pf_offset_regs.sv
module pf_offset_regs #(
    parameter int unsigned OFF_W       = 10,
    parameter int unsigned PRESETS [8] = '{7, 15, 31, 63, 127, 255, 511, 1023}
) (
    input  logic             clk,
    input  logic             mrst_n,
    input  logic             prst_n,
    input  logic [2:0]       dflt_sel,
    input  logic             ser_sel,
    input  logic             sync_sel,
    input  logic             ld_en,
    input  logic [OFF_W-1:0] ld_data,
    input  logic             ser_en,
    input  logic             ser_bit,
    output logic [OFF_W-1:0] ae_off,
    output logic [OFF_W-1:0] af_off,
    output pflag_pkg::cfg_t  cfg
);
    import pflag_pkg::*;

    localparam int unsigned SER_LEN = 2 * OFF_W;
    localparam int unsigned CNT_W   = $clog2(SER_LEN + 1);

    typedef struct packed {
        logic [OFF_W-1:0] ae_off;
        logic [OFF_W-1:0] af_off;
        logic             tgt_full;
        logic [CNT_W-1:0] bit_cnt;
        cfg_t             cfg;
    } st_t;

    st_t              s_d, s_q;
    logic [OFF_W-1:0] preset_val;

    always_comb preset_val = OFF_W'(PRESETS[dflt_sel]);

    always_comb begin
        s_d = s_q;
        if (!mrst_n) begin
            s_d.ae_off     = preset_val;
            s_d.af_off     = preset_val;
            s_d.tgt_full   = 1'b0;
            s_d.bit_cnt    = '0;
            s_d.cfg.load   = ser_sel  ? LD_SERIAL : LD_PARALLEL;
            s_d.cfg.timing = sync_sel ? TM_SYNC   : TM_ASYNC;
        end else if (!prst_n) begin
            s_d.tgt_full = 1'b0;
            s_d.bit_cnt  = '0;
        end else if (s_q.cfg.load == LD_PARALLEL) begin
            if (ld_en) begin
                if (s_q.tgt_full) s_d.af_off = ld_data;
                else              s_d.ae_off = ld_data;
                s_d.tgt_full = !s_q.tgt_full;
            end
        end else if (ser_en && (s_q.bit_cnt < CNT_W'(SER_LEN))) begin
            for (int i = 0; i < OFF_W; i++) begin
                if (s_q.bit_cnt == CNT_W'(i))         s_d.ae_off[i] = ser_bit;
                if (s_q.bit_cnt == CNT_W'(i + OFF_W)) s_d.af_off[i] = ser_bit;
            end
            s_d.bit_cnt = s_q.bit_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign ae_off = s_q.ae_off;
    assign af_off = s_q.af_off;
    assign cfg    = s_q.cfg;

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!mrst_n)
        (!(ld_en && s_q.cfg.load == LD_PARALLEL) && !(ser_en && s_q.cfg.load == LD_SERIAL))
        |=> ($stable(ae_off) && $stable(af_off)));

    // R4
    target_flip_chk: assert property (@(posedge clk) disable iff (!mrst_n)
        (prst_n && ld_en && s_q.cfg.load == LD_PARALLEL)
        |=> (s_q.tgt_full != $past(s_q.tgt_full)));

    // R6
    stream_end_chk: assert property (@(posedge clk) disable iff (!mrst_n)
        (prst_n && s_q.cfg.load == LD_SERIAL && s_q.bit_cnt == CNT_W'(SER_LEN))
        |=> ($stable(ae_off) && $stable(af_off)));
endmodule

// File: rtl/pf_gray_sync.sv
module pf_gray_sync #(
    parameter int unsigned W = 11
) (
    input  logic         src_clk,
    input  logic         src_rst_n,
    input  logic [W-1:0] src_bin,
    input  logic         dst_clk,
    input  logic         dst_rst_n,
    output logic [W-1:0] dst_bin
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } dst_t;

    logic [W-1:0] src_gray_d, src_gray_q;
    dst_t         dst_d, dst_q;

    always_comb src_gray_d = src_rst_n ? (src_bin ^ (src_bin >> 1)) : '0;

    always_ff @(posedge src_clk) begin
        src_gray_q <= src_gray_d;
    end

    always_comb begin
        dst_d.s1 = dst_rst_n ? src_gray_q : '0;
        dst_d.s2 = dst_rst_n ? dst_q.s1   : '0;
    end

    always_ff @(posedge dst_clk) begin
        dst_q <= dst_d;
    end

    always_comb begin
        for (int i = 0; i < W; i++) dst_bin[i] = ^(dst_q.s2 >> i);
    end
endmodule

// File: rtl/pf_flag_eval.sv
module pf_flag_eval #(
    parameter int unsigned PTR_W   = 11,
    parameter int unsigned OFF_W   = 10,
    parameter bit          IS_FULL = 1'b0,
    parameter bit          RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_en,
    input  logic [PTR_W-1:0] wp_loc,
    input  logic [PTR_W-1:0] rp_loc,
    input  logic [PTR_W-1:0] wp_raw,
    input  logic [PTR_W-1:0] rp_raw,
    input  logic [OFF_W-1:0] off,
    output logic             flag
);
    localparam logic [PTR_W-1:0] DEPTH = PTR_W'(1) << OFF_W;

    logic [PTR_W-1:0] fill_s, fill_a, lim;
    logic             hit_s, hit_a;
    logic             flag_d, flag_q;

    always_comb begin
        fill_s = wp_loc - rp_loc;
        fill_a = wp_raw - rp_raw;
        lim    = PTR_W'(off);
    end

    generate
        if (IS_FULL) begin : g_full
            always_comb begin
                hit_s = (DEPTH - fill_s) <= lim;
                hit_a = (DEPTH - fill_a) <= lim;
            end
        end else begin : g_empty
            always_comb begin
                hit_s = fill_s <= lim;
                hit_a = fill_a <= lim;
            end
        end
    endgenerate

    always_comb flag_d = rst_n ? hit_s : RST_VAL;

    always_ff @(posedge clk) begin
        flag_q <= flag_d;
    end

    assign flag = sync_en ? flag_q : hit_a;
endmodule

// File: rtl/pf_flag_unit.sv
module pf_flag_unit #(
    parameter int unsigned ADDR_W      = 10,
    parameter int unsigned PRESETS [8] = '{7, 15, 31, 63, 127, 255, 511, 1023}
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              mrst_n,
    input  logic              prst_n,
    input  logic [2:0]        dflt_sel,
    input  logic              ser_load_sel,
    input  logic              sync_sel,
    input  logic [ADDR_W:0]   wr_ptr,
    input  logic [ADDR_W:0]   rd_ptr,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_data,
    input  logic              ser_en,
    input  logic              ser_bit,
    output logic              ae_flag,
    output logic              af_flag
);
    import pflag_pkg::*;

    localparam int unsigned PTR_W = ADDR_W + 1;
    localparam int unsigned OFF_W = ADDR_W;
    localparam logic [PTR_W-1:0] DEPTH = PTR_W'(1) << ADDR_W;

    logic [OFF_W-1:0] ae_off, af_off;
    cfg_t             cfg;
    logic             run_n, sync_on;
    logic [PTR_W-1:0] wp_in_rd, rp_in_wr, fill_raw;

    assign run_n    = mrst_n & prst_n;
    assign sync_on  = (cfg.timing == TM_SYNC);
    assign fill_raw = wr_ptr - rd_ptr;

    pf_offset_regs #(.OFF_W(OFF_W), .PRESETS(PRESETS)) offs_i (
        .clk(wr_clk), .mrst_n(mrst_n), .prst_n(prst_n), .dflt_sel(dflt_sel),
        .ser_sel(ser_load_sel), .sync_sel(sync_sel), .ld_en(ld_en), .ld_data(ld_data),
        .ser_en(ser_en), .ser_bit(ser_bit), .ae_off(ae_off), .af_off(af_off), .cfg(cfg)
    );

    pf_gray_sync #(.W(PTR_W)) wsync_i (
        .src_clk(wr_clk), .src_rst_n(run_n), .src_bin(wr_ptr),
        .dst_clk(rd_clk), .dst_rst_n(run_n), .dst_bin(wp_in_rd)
    );

    pf_gray_sync #(.W(PTR_W)) rsync_i (
        .src_clk(rd_clk), .src_rst_n(run_n), .src_bin(rd_ptr),
        .dst_clk(wr_clk), .dst_rst_n(run_n), .dst_bin(rp_in_wr)
    );

    pf_flag_eval #(.PTR_W(PTR_W), .OFF_W(OFF_W), .IS_FULL(1'b0), .RST_VAL(1'b1)) ae_i (
        .clk(rd_clk), .rst_n(run_n), .sync_en(sync_on),
        .wp_loc(wp_in_rd), .rp_loc(rd_ptr), .wp_raw(wr_ptr), .rp_raw(rd_ptr),
        .off(ae_off), .flag(ae_flag)
    );

    pf_flag_eval #(.PTR_W(PTR_W), .OFF_W(OFF_W), .IS_FULL(1'b1), .RST_VAL(1'b0)) af_i (
        .clk(wr_clk), .rst_n(run_n), .sync_en(sync_on),
        .wp_loc(wr_ptr), .rp_loc(rp_in_wr), .wp_raw(wr_ptr), .rp_raw(rd_ptr),
        .off(af_off), .flag(af_flag)
    );

    // R2
    empty_raises_ae_chk: assert property (@(posedge wr_clk) disable iff (!mrst_n)
        (!sync_on && fill_raw == '0) |-> ae_flag);

    // R3
    full_raises_af_chk: assert property (@(posedge wr_clk) disable iff (!mrst_n)
        (!sync_on && fill_raw == DEPTH) |-> af_flag);
endmodule

// File: tb/pf_flag_unit_tb_top.sv
module pf_flag_unit_tb_top;
    localparam int AW = 10;

    logic          wr_clk = 1'b0, rd_clk = 1'b0;
    logic          mrst_n = 1'b0, prst_n = 1'b1;
    logic [2:0]    dflt_sel = '0;
    logic          ser_load_sel = 1'b0, sync_sel = 1'b0;
    logic [AW:0]   wr_ptr = '0, rd_ptr = '0;
    logic          ld_en = 1'b0;
    logic [AW-1:0] ld_data = '0;
    logic          ser_en = 1'b0, ser_bit = 1'b0;
    logic          ae_flag, af_flag;

    int n_chk = 0;
    int n_bad = 0;

    always #4 wr_clk = ~wr_clk;
    always #5 rd_clk = ~rd_clk;

    pf_flag_unit #(.ADDR_W(AW)) dut_i (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst_n(mrst_n), .prst_n(prst_n),
        .dflt_sel(dflt_sel), .ser_load_sel(ser_load_sel), .sync_sel(sync_sel),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .ld_en(ld_en), .ld_data(ld_data),
        .ser_en(ser_en), .ser_bit(ser_bit), .ae_flag(ae_flag), .af_flag(af_flag)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic do_mrst(input int sel, input bit ser, input bit syn);
        @(negedge wr_clk);
        mrst_n = 1'b0; dflt_sel = 3'(sel); ser_load_sel = ser; sync_sel = syn;
        wr_ptr = '0; rd_ptr = '0;
        repeat (6) @(negedge wr_clk);
        mrst_n = 1'b1;
        repeat (2) @(negedge wr_clk);
    endtask

    task automatic set_fill(input int w, input int r);
        @(negedge wr_clk);
        wr_ptr = (AW + 1)'(w); rd_ptr = (AW + 1)'(r);
        #1;
    endtask

    task automatic probe(input int fill, input logic exp_ae, input logic exp_af, input string tag);
        set_fill(fill, 0);
        check(ae_flag, exp_ae, {tag, " ae"});
        check(af_flag, exp_af, {tag, " af"});
    endtask

    task automatic par_write(input int val);
        @(negedge wr_clk);
        ld_en = 1'b1; ld_data = AW'(val);
        @(negedge wr_clk);
        ld_en = 1'b0;
    endtask

    task automatic shift_bits(input int val, input int nb);
        for (int i = 0; i < nb; i++) begin
            @(negedge wr_clk);
            ser_en = 1'b1; ser_bit = val[i];
        end
        @(negedge wr_clk);
        ser_en = 1'b0;
    endtask

    task automatic t_defaults();
        do_mrst(0, 1'b0, 1'b0);
        check(ae_flag, 1'b1, "R1 reset ae");
        check(af_flag, 1'b0, "R1 reset af");
        probe(7, 1'b1, 1'b0, "R1 R2 fill 7");
        probe(8, 1'b0, 1'b0, "R1 R2 fill 8");
        probe(1017, 1'b0, 1'b1, "R3 free 7");
        probe(1016, 1'b0, 1'b0, "R3 free 8");
        set_fill(2, 2043);
        check(ae_flag, 1'b1, "R2 wrapped fill 7");
        set_fill(3, 2043);
        check(ae_flag, 1'b0, "R2 wrapped fill 8");
        set_fill(1024, 0);
        check(af_flag, 1'b1, "R3 full");
    endtask

    task automatic t_parallel();
        par_write(100);
        par_write(200);
        probe(100, 1'b1, 1'b0, "R4 empty off 100");
        probe(101, 1'b0, 1'b0, "R4 empty off 101");
        probe(824, 1'b0, 1'b1, "R4 full off 200");
        probe(823, 1'b0, 1'b0, "R4 full off 201");
        shift_bits(32'hFFFFF, 20);
        probe(101, 1'b0, 1'b0, "R7 serial ignored ae");
        probe(823, 1'b0, 1'b0, "R7 serial ignored af");
    endtask

    task automatic t_partial();
        @(negedge wr_clk);
        prst_n = 1'b0;
        repeat (3) @(negedge wr_clk);
        prst_n = 1'b1;
        probe(100, 1'b1, 1'b0, "R5 empty off kept");
        probe(824, 1'b0, 1'b1, "R5 full off kept");
        par_write(50);
        probe(50, 1'b1, 1'b0, "R5 target back to empty");
        probe(51, 1'b0, 1'b0, "R5 empty off 51");
        probe(823, 1'b0, 1'b0, "R5 full off untouched");
        probe(824, 1'b0, 1'b1, "R5 full off still 200");
    endtask

    task automatic t_restore();
        do_mrst(3, 1'b0, 1'b0);
        probe(63, 1'b1, 1'b0, "R8 restore ae 63");
        probe(64, 1'b0, 1'b0, "R8 restore ae 64");
        probe(961, 1'b0, 1'b1, "R8 restore af 63");
        probe(960, 1'b0, 1'b0, "R8 restore af 64");
    endtask

    task automatic t_serial();
        do_mrst(1, 1'b1, 1'b0);
        par_write(300);
        probe(16, 1'b0, 1'b0, "R7 parallel ignored");
        probe(15, 1'b1, 1'b0, "R7 preset 15 kept");
        shift_bits(5, AW);
        shift_bits(9, AW);
        shift_bits(32'h1F, 5);
        probe(5, 1'b1, 1'b0, "R6 empty off 5");
        probe(6, 1'b0, 1'b0, "R6 empty off 6");
        probe(1015, 1'b0, 1'b1, "R6 full off 9");
        probe(1014, 1'b0, 1'b0, "R6 full off 10");
        probe(0, 1'b1, 1'b0, "R9 async follows");
    endtask

    task automatic t_sync();
        do_mrst(2, 1'b0, 1'b1);
        sync_sel = 1'b0;
        dflt_sel = 3'd7;
        repeat (12) @(negedge wr_clk);
        check(ae_flag, 1'b1, "R10 sync reset ae");
        set_fill(40, 0);
        check(ae_flag, 1'b1, "R10 R11 ae not combinational");
        repeat (12) @(negedge wr_clk);
        check(ae_flag, 1'b0, "R10 ae after sync");
        set_fill(993, 0);
        check(af_flag, 1'b0, "R10 af not combinational");
        repeat (12) @(negedge wr_clk);
        check(af_flag, 1'b1, "R10 R11 af after sync off 31");
        set_fill(992, 0);
        repeat (12) @(negedge wr_clk);
        check(af_flag, 1'b0, "R10 af free 32");
        set_fill(31, 0);
        repeat (12) @(negedge wr_clk);
        check(ae_flag, 1'b1, "R10 ae fill 31");
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_defaults();
        t_parallel();
        t_partial();
        t_restore();
        t_serial();
        t_sync();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule